// File: doc/BRIEF.md
# Two-Phase Fixed Off-Time Chopping Controller

This block regulates the winding current of a two-phase motor driver by chopping each phase's output switch. Every chopping cycle switches the phase on. It then ignores that phase's current comparator for a blanking window, so the switching spike cannot trip it. The output turns off at the first comparator trip after the window and then stays off for a fixed time. The length of that off-time comes from the phase's 4-bit current-ratio code. Small ratio codes get shorter off-times, so low currents are regulated with less ripple.

Two variants are chosen by a parameter. The microstep variant uses a short blanking window and three off-time levels. The full/half-step variant uses a longer blanking window and one off-time for every code. All times are counted in clock cycles derived from a clock-frequency parameter. A synchronous mode makes both phases chop together. It applies only while it is enabled and both phases carry the two-phase hold code 8. In that mode a trip on either phase ends the on-time of both phases, and both share one off-time. A hold-off input forces both outputs off. A one-cycle marker pulse flags the start of each off-time.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, both gate outputs and both off-pulse outputs are 0.
- R2: After a phase's gate turns on, its comparator is ignored for BLANK cycles: 1.7 µs (17 cycles at 10 MHz) in the microstep variant (`MICRO`=1) and 3.2 µs (32 cycles) in the full/half variant (`MICRO`=0). With the comparator held high, the gate therefore stays on for BLANK+1 cycles.
- R3: In the microstep variant, the off-time after a trip is 12 µs for ratio codes 8 to 15 (120 cycles at 10 MHz), 9 µs for codes 4 to 7 (90 cycles) and 7 µs for codes 1 to 3 (70 cycles).
- R4: In the full/half variant, every nonzero ratio code gives a 12 µs off-time.
- R5: Ratio code 0 holds that phase's gate at 0 with no off-pulses, from the first clock edge at which the code is sampled.
- R6: While `hold_off` is 1, both gates are 0 from the first clock edge at which it is sampled, and no off-pulses are issued.
- R7: Each comparator-ended on-time produces exactly one off-pulse. The pulse lasts one cycle and coincides with the first cycle that the gate is off.
- R8: With its comparator low after blanking, a phase's gate stays on and issues no off-pulse.
- R9: When `sync_en` is 1 and both ratio codes are 8, a trip of either comparator after its own blanking turns both gates off at the same edge with two off-pulses. Both phases then share one off-time and turn on again together.
- R10: When either ratio code is not 8, or `sync_en` is 0, each phase chops on its own, and a trip on one phase leaves the other phase's gate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by `CLK_HZ` |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_off | input | 1 | 1 forces both gates off |
| sync_en | input | 1 | Allows synchronous chopping when both codes are 8 |
| cmp_a | input | 1 | Phase A current comparator, 1 = current above limit |
| cmp_b | input | 1 | Phase B current comparator |
| ratio_a | input | 4 | Phase A current-ratio code, 0 = phase off |
| ratio_b | input | 4 | Phase B current-ratio code |
| gate_a | output | 1 | Phase A output switch enable |
| gate_b | output | 1 | Phase B output switch enable |
| offpulse_a | output | 1 | One-cycle marker at the start of a phase A off-time |
| offpulse_b | output | 1 | One-cycle marker at the start of a phase B off-time |

## Verification
The bench holds a comparator high and measures the on-run and off-run lengths at the gate for codes on both sides of each off-time boundary (3/4 and 7/8). A level decoder that is off by one code would give the wrong run length at one of these boundaries. The same stimulus drives the full/half variant, which must show one off-time and the longer blanking. Blanking one cycle short or long shows up directly in the on-run length. A one-cycle trip on phase B is used in the synchronous case, which must turn phase A off at the same edge with a shared off-time. The same trip is repeated with the codes 8 and 4, where phase A must keep running. Code 0 and hold-off are checked for any stray gate or off-pulse over a long window.

// File: rtl/chop_pkg.sv
// Shared types and helpers for the chopping controller.
// Assumes every time is expressed in tenths of a microsecond.
package chop_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_ON    = 2'd2,
        PH_OFF   = 2'd3
    } ph_state_e;

    // Ratio code that allows both phases to chop together.
    localparam logic [3:0] SYNC_CODE = 4'h8;

    // Converts a time in tenths of a microsecond into clock cycles, minimum 1.
    function automatic int unsigned tenths_to_cyc(input int unsigned clk_hz,
                                                  input int unsigned tenths);
        int unsigned c;
        c = ((clk_hz / 1000) * tenths) / 10000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/chop_offsel.sv
// Off-time selector: maps a current-ratio code to an off-time in cycles.
// The microstep variant has three levels and the full/half variant has one.
// Assumes OFF_HI >= OFF_MID >= OFF_LO >= 1 and that all fit in CNT_W bits.
module chop_offsel #(
    parameter int unsigned CNT_W   = 8,
    parameter bit          MICRO   = 1'b1,
    parameter int unsigned OFF_HI  = 120,
    parameter int unsigned OFF_MID = 90,
    parameter int unsigned OFF_LO  = 70
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] off_cyc
);
    generate
        if (MICRO) begin : g_micro
            // Three-level decode on the upper code range boundaries.
            always_comb begin
                if (code[3])
                    off_cyc = CNT_W'(OFF_HI);
                else if (code[2])
                    off_cyc = CNT_W'(OFF_MID);
                else
                    off_cyc = CNT_W'(OFF_LO);
            end
        end else begin : g_single
            logic unused_code;
            assign unused_code = ^code;
            // A single off-time for every code.
            assign off_cyc = CNT_W'(OFF_HI);
        end
    endgenerate
endmodule

// File: rtl/chop_phase.sv
// One phase of the chopper: idle, blanking, on, and fixed off-time states.
// kill forces idle with no pulse. In sync mode the shared trip ends the
// on-time and reloads the off-time of any active phase.
// Assumes BLANK_CYC >= 1 and off_cyc >= 1.
module chop_phase
    import chop_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned BLANK_CYC = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             comp,
    input  logic             sync_mode,
    input  logic             sync_trip,
    input  logic [CNT_W-1:0] off_cyc,
    output logic             gate_on,
    output logic             pwm_off,
    output logic             trip_req
);
    ph_state_e        st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             enter_off;
    logic             pulse_n;

    // Next state and counter for one chopping cycle.
    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        enter_off = 1'b0;
        case (st)
            PH_IDLE: begin
                if (!kill) begin
                    st_n  = PH_BLANK;
                    cnt_n = '0;
                end
            end
            PH_BLANK: begin
                if (sync_mode && sync_trip)
                    enter_off = 1'b1;
                else if (cnt == CNT_W'(BLANK_CYC - 1))
                    st_n = PH_ON;
                else
                    cnt_n = cnt + 1'b1;
            end
            PH_ON: begin
                if (sync_mode ? sync_trip : comp)
                    enter_off = 1'b1;
            end
            default: begin
                if (sync_mode && sync_trip)
                    enter_off = 1'b1;
                else if (cnt == '0) begin
                    st_n  = PH_BLANK;
                    cnt_n = '0;
                end else
                    cnt_n = cnt - 1'b1;
            end
        endcase
        if (enter_off) begin
            st_n  = PH_OFF;
            cnt_n = off_cyc - 1'b1;
        end
        if (kill) begin
            st_n  = PH_IDLE;
            cnt_n = '0;
        end
    end

    assign pulse_n = enter_off && !kill && (st == PH_BLANK || st == PH_ON);

    // State, counter and off-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            cnt     <= '0;
            pwm_off <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            pwm_off <= pulse_n;
        end
    end

    assign gate_on  = (st == PH_BLANK) || (st == PH_ON);
    assign trip_req = (st == PH_ON) && comp;

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_off |=> !pwm_off);
    assert_pulse_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_off |-> !gate_on);
    assert_kill_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!gate_on && !pwm_off));
    assert_blank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_BLANK && !kill && !(sync_mode && sync_trip)) |=> gate_on);
endmodule

// File: rtl/chop_ctrl.sv
// Two-phase fixed off-time chopping controller (top).
// Holds one chop_phase and one off-time selector per phase. It combines the
// trip requests into a shared trip for synchronous mode (both codes 8).
// Assumes the comparator inputs are already synchronous to clk.
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned CLK_HZ = 10_000_000,
    parameter bit          MICRO  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_off,
    input  logic       sync_en,
    input  logic       cmp_a,
    input  logic       cmp_b,
    input  logic [3:0] ratio_a,
    input  logic [3:0] ratio_b,
    output logic       gate_a,
    output logic       gate_b,
    output logic       offpulse_a,
    output logic       offpulse_b
);
    localparam int          NPH       = 2;
    localparam int unsigned BLANK_CYC = tenths_to_cyc(CLK_HZ, MICRO ? 17 : 32);
    localparam int unsigned OFF_HI    = tenths_to_cyc(CLK_HZ, 120);
    localparam int unsigned OFF_MID   = tenths_to_cyc(CLK_HZ, 90);
    localparam int unsigned OFF_LO    = tenths_to_cyc(CLK_HZ, 70);
    localparam int unsigned CNT_MAX   = (OFF_HI > BLANK_CYC) ? OFF_HI : BLANK_CYC;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    logic [3:0] code   [NPH];
    logic [NPH-1:0] comp, gate, pulse, trip;
    logic sync_act, sync_trip;

    assign code[0] = ratio_a;
    assign code[1] = ratio_b;
    assign comp    = {cmp_b, cmp_a};

    // Synchronous chopping applies only to the two-phase hold code on both phases.
    assign sync_act  = sync_en && (ratio_a == SYNC_CODE) && (ratio_b == SYNC_CODE);
    assign sync_trip = |trip;

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_ph
            logic [CNT_W-1:0] off_cyc;

            chop_offsel #(
                .CNT_W  (CNT_W),
                .MICRO  (MICRO),
                .OFF_HI (OFF_HI),
                .OFF_MID(OFF_MID),
                .OFF_LO (OFF_LO)
            ) u_sel (
                .code   (code[p]),
                .off_cyc(off_cyc)
            );

            chop_phase #(
                .CNT_W    (CNT_W),
                .BLANK_CYC(BLANK_CYC)
            ) u_ph (
                .clk      (clk),
                .rst_n    (rst_n),
                .kill     (hold_off || (code[p] == 4'h0)),
                .comp     (comp[p]),
                .sync_mode(sync_act),
                .sync_trip(sync_trip),
                .off_cyc  (off_cyc),
                .gate_on  (gate[p]),
                .pwm_off  (pulse[p]),
                .trip_req (trip[p])
            );
        end
    endgenerate

    assign gate_a     = gate[0];
    assign gate_b     = gate[1];
    assign offpulse_a = pulse[0];
    assign offpulse_b = pulse[1];

    assert_code0_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_a == 4'h0) |=> (!gate_a && !offpulse_a));
    assert_sync_pair_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_act && gate_a && gate_b && !hold_off) && offpulse_a) |-> offpulse_b);
    assert_sync_pair_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_act && gate_a && gate_b && !hold_off) && offpulse_b) |-> offpulse_a);
    assert_indep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!sync_act && gate_a && !cmp_a && !hold_off && ratio_a != 4'h0)) |-> gate_a);
endmodule

// File: tb/sim_chop_ctrl.sv
module sim_chop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10_000_000;
    localparam int CPU        = CLK_HZ / 1_000_000;  // cycles per microsecond

    // Expected times from the requirements.
    localparam int BLANK_MICRO = CPU * 17 / 10;
    localparam int BLANK_FULL  = CPU * 32 / 10;
    localparam int T12 = CPU * 12;
    localparam int T9  = CPU * 9;
    localparam int T7  = CPU * 7;

    localparam int NVEC = 7;
    localparam logic [3:0] VEC_CODE [NVEC] = '{4'h1, 4'h3, 4'h4, 4'h7, 4'h8, 4'h9, 4'hF};
    localparam int         VEC_OFF  [NVEC] = '{T7, T7, T9, T9, T12, T12, T12};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_off = 1'b0, sync_en = 1'b0, cmp_a = 1'b0, cmp_b = 1'b0;
    logic [3:0] ratio_a = 4'h0, ratio_b = 4'h0;
    logic gate_a, gate_b, offpulse_a, offpulse_b;
    logic f_gate_a, f_gate_b, f_off_a, f_off_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chop_ctrl #(.CLK_HZ(CLK_HZ), .MICRO(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .sync_en(sync_en),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .ratio_a(ratio_a), .ratio_b(ratio_b),
        .gate_a(gate_a), .gate_b(gate_b), .offpulse_a(offpulse_a), .offpulse_b(offpulse_b));

    chop_ctrl #(.CLK_HZ(CLK_HZ), .MICRO(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .sync_en(sync_en),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .ratio_a(ratio_a), .ratio_b(ratio_b),
        .gate_a(f_gate_a), .gate_b(f_gate_b), .offpulse_a(f_off_a), .offpulse_b(f_off_b));

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sel_gate(input int sel);
        return (sel == 0) ? gate_a : f_gate_a;
    endfunction

    function automatic logic sel_pulse(input int sel);
        return (sel == 0) ? offpulse_a : f_off_a;
    endfunction

    // Waits for a gate fall, then measures the off run, its pulses and the next on run.
    task automatic measure(input int sel, output int lo, output int hi,
                           output int npulse, output int first_pulse);
        logic cur, prev;
        int guard = 0;
        cur = sel_gate(sel);
        forever begin
            prev = cur;
            @(negedge clk);
            cur = sel_gate(sel);
            guard++;
            if ((prev && !cur) || guard > 1000) break;
        end
        first_pulse = int'(sel_pulse(sel));
        lo = 0; npulse = 0; hi = 0;
        while (!cur && lo < 2000) begin
            lo++;
            npulse += int'(sel_pulse(sel));
            @(negedge clk);
            cur = sel_gate(sel);
        end
        while (cur && hi < 2000) begin
            hi++;
            @(negedge clk);
            cur = sel_gate(sel);
        end
    endtask

    task automatic restart_phases();
        hold_off = 1'b1;
        repeat (3) @(negedge clk);
        hold_off = 1'b0;
    endtask

    initial begin
        int lo, hi, np, fp, bad;

        // R1: reset state
        repeat (4) @(negedge clk);
        check_int("R1 gates in reset", {gate_a, gate_b, f_gate_a, f_gate_b}, 0);
        check_int("R1 pulses in reset", {offpulse_a, offpulse_b, f_off_a, f_off_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 gates after reset", {gate_a, gate_b}, 0);

        // Vector table: off-time per code (R3, R4), blanking (R2), pulse (R7).
        cmp_a = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            ratio_a = VEC_CODE[i];
            measure(0, lo, hi, np, fp);
            check_int($sformatf("R3 micro off-time code %0d", VEC_CODE[i]), lo, VEC_OFF[i]);
            check_int("R2 micro on-time with comparator high", hi, BLANK_MICRO + 1);
            check_int("R7 single pulse per off-time", np, 1);
            check_int("R7 pulse on first off cycle", fp, 1);
            measure(1, lo, hi, np, fp);
            check_int($sformatf("R4 full/half off-time code %0d", VEC_CODE[i]), lo, T12);
            check_int("R2 full/half on-time with comparator high", hi, BLANK_FULL + 1);
        end

        // R5: code 0 holds the phase off with no pulses.
        ratio_a = 4'h0;
        @(negedge clk);
        bad = 0;
        repeat (300) begin
            bad += int'(gate_a) + int'(offpulse_a);
            @(negedge clk);
        end
        check_int("R5 code 0 gate/pulse activity", bad, 0);

        // R8: comparator low keeps the gate on.
        ratio_a = 4'h8; cmp_a = 1'b0;
        repeat (40) @(negedge clk);
        bad = 0;
        repeat (300) begin
            bad += int'(!gate_a) + int'(offpulse_a);
            @(negedge clk);
        end
        check_int("R8 comparator low no chop", bad, 0);

        // R6: hold-off forces both gates off on the next edge.
        cmp_a = 1'b1; ratio_b = 4'h8;
        repeat (25) @(negedge clk);
        hold_off = 1'b1;
        @(negedge clk);
        check_int("R6 gates off after hold", {gate_a, gate_b}, 0);
        bad = 0;
        repeat (50) begin
            bad += int'(gate_a) + int'(gate_b) + int'(offpulse_a) + int'(offpulse_b);
            @(negedge clk);
        end
        check_int("R6 no activity while held", bad, 0);
        hold_off = 1'b0;

        // R9: synchronous chopping with both codes 8.
        cmp_a = 1'b0; cmp_b = 1'b0; sync_en = 1'b1; ratio_a = 4'h8; ratio_b = 4'h8;
        restart_phases();
        repeat (40) @(negedge clk);
        check_int("R9 both on before trip", {gate_a, gate_b}, 2'b11);
        cmp_b = 1'b1;
        @(negedge clk);
        cmp_b = 1'b0;
        check_int("R9 both off and pulsed", {gate_a, gate_b, offpulse_a, offpulse_b}, 4'b0011);
        lo = 0; bad = 0;
        while (!gate_a && lo < 2000) begin
            lo++;
            bad += int'(gate_a != gate_b);
            @(negedge clk);
        end
        bad += int'(gate_a != gate_b);
        check_int("R9 shared off-time", lo, T12);
        check_int("R9 phases aligned", bad, 0);

        // R10: codes 8 and 4 chop independently even with sync enabled.
        ratio_b = 4'h4;
        restart_phases();
        repeat (40) @(negedge clk);
        cmp_b = 1'b1;
        @(negedge clk);
        cmp_b = 1'b0;
        check_int("R10 only tripped phase off", {gate_a, gate_b, offpulse_a, offpulse_b}, 4'b1001);

        finish_run();
    end
endmodule